// File: doc/BRIEF.md
# Watchdog Timer with Unlock-Style Feed

This block is a watchdog peripheral that sits on a simple register bus. The bus has a write strobe, a byte address and 32-bit write data, and read data comes back combinationally. Software sets sticky enable bits in a mode register and loads a reload constant. It then proves it is alive by writing a two-byte key to the feed register. A completed key reloads a down-counter, and when the watchdog is enabled the same key also arms it. The counter steps once every four clock cycles. If software stops feeding and the count runs out, the block either raises a level interrupt or emits a one-cycle request for a system reset, depending on the mode bits.

Two reset inputs are kept apart. The external reset clears everything. The watchdog-caused reset is a synchronous input that the system drives from the block's own reset request. It clears the enable bits, the interrupt flag and the armed state, but it leaves the time-out flag set so that software can see after the restart why it happened.

Register offsets: mode at 0x0, reload constant at 0x4, feed at 0x8. Any other address reads as zero.

Top module: `wdog_core`

## Requirements
- R1: After the external reset, the mode register (0x0) reads 0, the reload constant (0x4) reads 0x000000FF, and both `irq_o` and `rst_req_o` are low.
- R2: The mode bits are laid out as: enable at bit 0, reset-enable at bit 1, time-out flag at bit 2 and interrupt flag at bit 3. A mode write ORs bits 0 and 1 into the stored enable and reset-enable bits, so a write can never clear either of them.
- R3: A write to the reload constant stores 0x000000FF when the written value is below 0xFF. Otherwise it stores the written value unchanged.
- R4: A feed is a write of 0xAA to the feed register (low byte) followed by a feed write of 0x55. If the write after 0xAA has any other low byte, the sequence is aborted, and a later 0x55 on its own does nothing.
- R5: Setting the enable bit without a completed feed never produces a time-out.
- R6: Let E be the clock edge that takes in the 0x55 byte, and let C be the reload constant. When the enable bit is set, the time-out falls on the edge E + 4·(C+1).
- R7: With enable=1 and reset-enable=0, a time-out sets the interrupt flag and the time-out flag, and `rst_req_o` stays low. `irq_o` stays high until a reset. After the time-out the counter halts, so no further time-out occurs until the next feed.
- R8: With enable=1 and reset-enable=1, a time-out drives `rst_req_o` high for exactly the one cycle that follows the time-out edge.
- R9: A pulse on `wdt_rst_i` clears the enable bit, the reset-enable bit and the interrupt flag, but it keeps the time-out flag.
- R10: A mode write with bit 2 at 0 clears the time-out flag. A mode write with bit 2 at 1 leaves the flag unchanged.
- R11: A feed that completes while the counter is running restarts the full interval, counted from the new feed.
- R12: If a feed completes on the same edge as a time-out would fall, the feed wins: no time-out occurs, and a new interval starts from that edge.
- R13: The external reset also clears the time-out flag.
- R14: After a time-out in interrupt mode, a new feed re-arms the counter, and a second time-out follows after the full interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Watchdog clock |
| rst_ext_ni | input | 1 | External reset, asynchronous, active low |
| wdt_rst_i | input | 1 | Reset caused by the watchdog, synchronous, active high |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed register |
| irq_o | output | 1 | Interrupt request, high while the interrupt flag is set |
| rst_req_o | output | 1 | One-cycle system-reset request |

## Verification
The feed and the time-out can fall on the same clock edge. In that case the reload has to win over the zero-count check in the counter. The bench provokes this by timing a second feed so that its 0x55 byte lands exactly 4·(C+1) edges after the first feed. It then judges the result at the ports: `irq_o` must stay low on that edge, and it must rise exactly one full interval later. A design that lets the time-out win instead shows `irq_o` rising one interval too early.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   localparam int unsigned ADDR_W = 4;

   localparam logic [ADDR_W-1:0] ADR_MODE   = 4'h0;
   localparam logic [ADDR_W-1:0] ADR_RELOAD = 4'h4;
   localparam logic [ADDR_W-1:0] ADR_FEED   = 4'h8;

   localparam logic [7:0] KEY_FIRST  = 8'hAA;
   localparam logic [7:0] KEY_SECOND = 8'h55;

   typedef enum logic [0:0] {
      FEED_IDLE = 1'b0,
      FEED_HALF = 1'b1
   } feed_st_e;

   // bit 3 .. bit 0 : interrupt flag, time-out flag, reset-enable, enable
   typedef struct packed {
      logic intf;
      logic tof;
      logic rsten;
      logic en;
   } mode_t;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned MIN_RELOAD = 255
) (
   input  logic              clk_i,
   input  logic              rst_ext_ni,
   input  logic              wdt_rst_i,
   input  logic              we_mode_i,
   input  logic              we_reload_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              set_tof_i,
   input  logic              set_int_i,
   output mode_t             mode_o,
   output logic [DATA_W-1:0] reload_o
);

   localparam logic [DATA_W-1:0] MIN_V = DATA_W'(MIN_RELOAD);

   logic              en_q, rsten_q, intf_q, tof_q;
   logic [DATA_W-1:0] reload_q;

   // Sticky bits, interrupt flag and reload constant: cleared by either reset
   always_ff @(posedge clk_i or negedge rst_ext_ni) begin
      if (!rst_ext_ni) begin
         en_q     <= 1'b0;
         rsten_q  <= 1'b0;
         intf_q   <= 1'b0;
         reload_q <= MIN_V;
      end else if (wdt_rst_i) begin
         en_q     <= 1'b0;
         rsten_q  <= 1'b0;
         intf_q   <= 1'b0;
         reload_q <= MIN_V;
      end else begin
         if (we_mode_i) begin
            en_q    <= en_q | wdata_i[0];
            rsten_q <= rsten_q | wdata_i[1];
         end
         if (set_int_i)
            intf_q <= 1'b1;
         if (we_reload_i)
            reload_q <= (wdata_i < MIN_V) ? MIN_V : wdata_i;
      end
   end

   // Time-out flag: only the external reset clears it; a set beats a clear
   always_ff @(posedge clk_i or negedge rst_ext_ni) begin
      if (!rst_ext_ni)
         tof_q <= 1'b0;
      else if (set_tof_i)
         tof_q <= 1'b1;
      else if (we_mode_i && !wdata_i[2])
         tof_q <= 1'b0;
   end

   assign mode_o   = '{intf: intf_q, tof: tof_q, rsten: rsten_q, en: en_q};
   assign reload_o = reload_q;

   a_r2_en_sticky: assert property (@(posedge clk_i) disable iff (!rst_ext_ni)
      (en_q && !wdt_rst_i) |=> en_q);
   a_r2_rsten_sticky: assert property (@(posedge clk_i) disable iff (!rst_ext_ni)
      (rsten_q && !wdt_rst_i) |=> rsten_q);
   a_r7_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ext_ni)
      (intf_q && !wdt_rst_i) |=> intf_q);
   a_r3_reload_floor: assert property (@(posedge clk_i) disable iff (!rst_ext_ni)
      reload_q >= MIN_V);
   a_r9_tof_kept: assert property (@(posedge clk_i) disable iff (!rst_ext_ni)
      (tof_q && wdt_rst_i) |=> tof_q);

endmodule

// File: rtl/wdog_feed.sv
module wdog_feed
   import wdog_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ext_ni,
   input  logic       wdt_rst_i,
   input  logic       we_feed_i,
   input  logic [7:0] key_i,
   output logic       feed_ok_o
);

   feed_st_e st_q, st_d;

   always_comb begin
      st_d      = st_q;
      feed_ok_o = 1'b0;
      if (we_feed_i) begin
         unique case (st_q)
            FEED_IDLE: st_d = (key_i == KEY_FIRST) ? FEED_HALF : FEED_IDLE;
            FEED_HALF: begin
               st_d      = FEED_IDLE;
               feed_ok_o = (key_i == KEY_SECOND);
            end
            default:   st_d = FEED_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ext_ni) begin
      if (!rst_ext_ni)
         st_q <= FEED_IDLE;
      else if (wdt_rst_i)
         st_q <= FEED_IDLE;
      else
         st_q <= st_d;
   end

   a_r4_ok_needs_half: assert property (@(posedge clk_i) disable iff (!rst_ext_ni)
      feed_ok_o |=> (st_q == FEED_IDLE));

endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
   parameter int unsigned PRESCALE = 4
) (
   input  logic clk_i,
   input  logic rst_ext_ni,
   input  logic wdt_rst_i,
   input  logic run_i,
   input  logic restart_i,
   output logic tick_o
);

   localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
   localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
   localparam bit IS_POW2 = (PRESCALE & (PRESCALE - 1)) == 0;

   logic [PW-1:0] cnt_q, cnt_d;

   assign tick_o = run_i && (cnt_q == LAST);

   generate
      if (IS_POW2) begin : g_wrap
         always_comb cnt_d = cnt_q + 1'b1;
      end else begin : g_cmp
         always_comb cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ext_ni) begin
      if (!rst_ext_ni)
         cnt_q <= '0;
      else if (wdt_rst_i || restart_i || !run_i)
         cnt_q <= '0;
      else
         cnt_q <= cnt_d;
   end

   a_r6_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ext_ni)
      tick_o |=> !tick_o);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned MIN_RELOAD = 255
) (
   input  logic              clk_i,
   input  logic              rst_ext_ni,
   input  logic              wdt_rst_i,
   input  logic              load_i,
   input  logic              arm_en_i,
   input  logic [DATA_W-1:0] reload_i,
   input  logic              tick_i,
   output logic              armed_o,
   output logic              timeout_o
);

   localparam logic [DATA_W-1:0] MIN_V = DATA_W'(MIN_RELOAD);

   logic [DATA_W-1:0] cnt_q;
   logic              armed_q;
   logic              at_zero;

   assign at_zero   = (cnt_q == '0);
   // a reload on the same edge takes precedence over the expiry
   assign timeout_o = armed_q && tick_i && at_zero && !load_i;
   assign armed_o   = armed_q;

   always_ff @(posedge clk_i or negedge rst_ext_ni) begin
      if (!rst_ext_ni) begin
         cnt_q   <= MIN_V;
         armed_q <= 1'b0;
      end else if (wdt_rst_i) begin
         cnt_q   <= MIN_V;
         armed_q <= 1'b0;
      end else if (load_i) begin
         cnt_q   <= reload_i;
         armed_q <= arm_en_i;
      end else if (timeout_o) begin
         armed_q <= 1'b0;
      end else if (armed_q && tick_i && !at_zero) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   a_r5_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ext_ni)
      (!armed_q && !load_i && !wdt_rst_i) |=> $stable(cnt_q));
   a_r7_halt_after: assert property (@(posedge clk_i) disable iff (!rst_ext_ni)
      (timeout_o && !wdt_rst_i) |=> (!armed_q && at_zero));

endmodule

// File: rtl/wdog_core.sv
module wdog_core
   import wdog_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned PRESCALE   = 4,
   parameter int unsigned MIN_RELOAD = 255
) (
   input  logic              clk_i,
   input  logic              rst_ext_ni,
   input  logic              wdt_rst_i,
   input  logic              bus_we_i,
   input  logic [3:0]        bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              irq_o,
   output logic              rst_req_o
);

   localparam int unsigned MODE_W = $bits(mode_t);

   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("wdog_core: DATA_W must be at least 8");
      end
      if (PRESCALE < 2) begin : g_bad_presc
         $error("wdog_core: PRESCALE must be at least 2");
      end
      if (DATA_W < 32 && MIN_RELOAD >= (1 << DATA_W)) begin : g_bad_min
         $error("wdog_core: MIN_RELOAD does not fit in DATA_W");
      end
   endgenerate

   mode_t             mode;
   logic [DATA_W-1:0] reload;
   logic              we_mode, we_reload, we_feed;
   logic              feed_ok, tick, armed, timeout;
   logic              rst_req_q;

   assign we_mode   = bus_we_i && (bus_addr_i == ADR_MODE);
   assign we_reload = bus_we_i && (bus_addr_i == ADR_RELOAD);
   assign we_feed   = bus_we_i && (bus_addr_i == ADR_FEED);

   wdog_regs #(.DATA_W(DATA_W), .MIN_RELOAD(MIN_RELOAD)) regs_i (
      .clk_i      (clk_i),
      .rst_ext_ni (rst_ext_ni),
      .wdt_rst_i  (wdt_rst_i),
      .we_mode_i  (we_mode),
      .we_reload_i(we_reload),
      .wdata_i    (bus_wdata_i),
      .set_tof_i  (timeout),
      .set_int_i  (timeout && !mode.rsten),
      .mode_o     (mode),
      .reload_o   (reload)
   );

   wdog_feed feed_i (
      .clk_i      (clk_i),
      .rst_ext_ni (rst_ext_ni),
      .wdt_rst_i  (wdt_rst_i),
      .we_feed_i  (we_feed),
      .key_i      (bus_wdata_i[7:0]),
      .feed_ok_o  (feed_ok)
   );

   wdog_prescale #(.PRESCALE(PRESCALE)) presc_i (
      .clk_i      (clk_i),
      .rst_ext_ni (rst_ext_ni),
      .wdt_rst_i  (wdt_rst_i),
      .run_i      (armed),
      .restart_i  (feed_ok),
      .tick_o     (tick)
   );

   wdog_counter #(.DATA_W(DATA_W), .MIN_RELOAD(MIN_RELOAD)) cnt_i (
      .clk_i      (clk_i),
      .rst_ext_ni (rst_ext_ni),
      .wdt_rst_i  (wdt_rst_i),
      .load_i     (feed_ok),
      .arm_en_i   (mode.en),
      .reload_i   (reload),
      .tick_i     (tick),
      .armed_o    (armed),
      .timeout_o  (timeout)
   );

   always_ff @(posedge clk_i or negedge rst_ext_ni) begin
      if (!rst_ext_ni)
         rst_req_q <= 1'b0;
      else if (wdt_rst_i)
         rst_req_q <= 1'b0;
      else
         rst_req_q <= timeout && mode.rsten;
   end

   always_comb begin
      unique case (bus_addr_i)
         ADR_MODE:   bus_rdata_o = {{(DATA_W-MODE_W){1'b0}}, mode};
         ADR_RELOAD: bus_rdata_o = reload;
         default:    bus_rdata_o = '0;
      endcase
   end

   assign irq_o     = mode.intf;
   assign rst_req_o = rst_req_q;

   a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ext_ni)
      rst_req_o |=> !rst_req_o);
   a_r7_irq_not_in_reset_mode: assert property (@(posedge clk_i) disable iff (!rst_ext_ni)
      ($rose(irq_o) && !$past(wdt_rst_i)) |-> !rst_req_o);
   a_r1_arm_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ext_ni)
      armed |-> mode.en);

endmodule

// File: tb/wdog_core_tb_top.sv
module wdog_core_tb_top;

   localparam int CLK_P   = 10;
   localparam int PRESC   = 4;
   localparam int DEF_RLD = 255;

   logic        clk = 1'b0;
   logic        rst_ext_n = 1'b0;
   logic        we = 1'b0;
   logic [3:0]  addr = 4'h0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq, rst_req;
   logic        wdt_rst;

   int checks = 0;
   int errors = 0;

   assign wdt_rst = rst_req;

   always #(CLK_P/2) clk = ~clk;

   wdog_core dut_i (
      .clk_i      (clk),
      .rst_ext_ni (rst_ext_n),
      .wdt_rst_i  (wdt_rst),
      .bus_we_i   (we),
      .bus_addr_i (addr),
      .bus_wdata_i(wdata),
      .bus_rdata_o(rdata),
      .irq_o      (irq),
      .rst_req_o  (rst_req)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // called just after a negedge; the write lands on the next posedge
   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      we = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      @(negedge clk);
      we = 1'b0; wdata = '0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic feed();
      wr(4'h8, 32'hAA);
      wr(4'h8, 32'h55);
   endtask

   task automatic ext_reset();
      rst_ext_n = 1'b0;
      idle(3);
      rst_ext_n = 1'b1;
      idle(1);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      ext_reset();
      rd(4'h0, v); chk("R1 mode after reset", v, 32'h0);
      rd(4'h4, v); chk("R1 reload after reset", v, 32'hFF);
      chk("R1 irq after reset", {31'b0, irq}, 32'h0);
      chk("R1 rst_req after reset", {31'b0, rst_req}, 32'h0);
   endtask

   task automatic t_clamp();
      logic [31:0] v;
      wr(4'h4, 32'h10);  rd(4'h4, v); chk("R3 clamp small", v, 32'hFF);
      wr(4'h4, 32'h100); rd(4'h4, v); chk("R3 keep large", v, 32'h100);
      wr(4'h4, 32'hFE);  rd(4'h4, v); chk("R3 clamp FE", v, 32'hFF);
   endtask

   task automatic t_sticky();
      logic [31:0] v;
      wr(4'h0, 32'h1); rd(4'h0, v); chk("R2 enable set", v, 32'h1);
      wr(4'h0, 32'h0); rd(4'h0, v); chk("R2 enable sticky", v, 32'h1);
   endtask

   task automatic t_no_arm();
      idle(PRESC * (DEF_RLD + 1) + 50);
      chk("R5 no time-out without feed", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_bad_feed();
      wr(4'h8, 32'hAA);
      wr(4'h8, 32'h12);
      wr(4'h8, 32'h55);
      idle(PRESC * (DEF_RLD + 1) + 50);
      chk("R4 aborted feed does not arm", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_int_mode();
      logic [31:0] v;
      feed();
      idle(PRESC * (DEF_RLD + 1) - 1);
      chk("R6 irq low one edge early", {31'b0, irq}, 32'h0);
      idle(1);
      chk("R6 irq at interval", {31'b0, irq}, 32'h1);
      chk("R7 no reset request in int mode", {31'b0, rst_req}, 32'h0);
      rd(4'h0, v); chk("R7 flags set", v, 32'hD);
      wr(4'h0, 32'h4); rd(4'h0, v); chk("R10 bit2=1 keeps tof", v, 32'hD);
      wr(4'h0, 32'h0); rd(4'h0, v); chk("R10 bit2=0 clears tof", v, 32'h9);
      idle(2000);
      rd(4'h0, v); chk("R7 counter halted", v, 32'h9);
      chk("R7 irq held", {31'b0, irq}, 32'h1);
   endtask

   task automatic t_rearm();
      logic [31:0] v;
      feed();
      idle(PRESC * (DEF_RLD + 1) - 1);
      rd(4'h0, v); chk("R14 tof low before second time-out", v, 32'h9);
      idle(1);
      rd(4'h0, v); chk("R14 second time-out", v, 32'hD);
      wr(4'h0, 32'h0);
   endtask

   task automatic t_reset_mode();
      logic [31:0] v;
      wr(4'h0, 32'h2);
      feed();
      idle(PRESC * (DEF_RLD + 1) - 1);
      chk("R8 no request early", {31'b0, rst_req}, 32'h0);
      idle(1);
      chk("R8 request pulse", {31'b0, rst_req}, 32'h1);
      idle(1);
      chk("R8 request one cycle", {31'b0, rst_req}, 32'h0);
      rd(4'h0, v); chk("R9 watchdog reset keeps tof only", v, 32'h4);
      chk("R9 irq cleared", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_ext_clears();
      logic [31:0] v;
      ext_reset();
      rd(4'h0, v); chk("R13 ext reset clears tof", v, 32'h0);
   endtask

   task automatic t_refeed();
      wr(4'h0, 32'h1);
      feed();
      idle(600);
      feed();
      idle(PRESC * (DEF_RLD + 1) - 1);
      chk("R11 refeed postpones", {31'b0, irq}, 32'h0);
      idle(1);
      chk("R11 time-out after refeed", {31'b0, irq}, 32'h1);
   endtask

   task automatic t_collide();
      ext_reset();
      wr(4'h0, 32'h1);
      feed();
      idle(PRESC * (DEF_RLD + 1) - 2);
      feed();
      chk("R12 feed wins on expiry edge", {31'b0, irq}, 32'h0);
      idle(PRESC * (DEF_RLD + 1) - 1);
      chk("R12 no early time-out", {31'b0, irq}, 32'h0);
      idle(1);
      chk("R12 new interval from feed", {31'b0, irq}, 32'h1);
   endtask

   initial begin
      #(CLK_P * 150000);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_clamp();
      t_sticky();
      t_no_arm();
      t_bad_feed();
      t_int_mode();
      t_rearm();
      t_reset_mode();
      t_ext_clears();
      t_refeed();
      t_collide();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule